// File: doc/BRIEF.md
# Processor Request to Wishbone Master Bridge

This block sits between a 64-bit processor core and a Wishbone B.3 bus. The core presents one memory request at a time: a strobe, a read/write flag, a 40-bit physical address, a target region code, an access size of 1, 2, 4 or 8 bytes, and right-justified write data. The bridge turns each accepted request into exactly one single read or single write bus cycle. It returns a one-cycle done pulse with the read value, which is zero-extended.

The bus address is always a full 64-bit value. A one-hot region prefix sits in the top five bits and the bits between the prefix and the physical address are forced to zero. The address is aligned to the 8-byte word, and the bytes touched are marked only by the eight byte-select lines. Byte lanes are big-endian: the lowest-addressed byte travels on data bits [63:56] under SEL[7]. A request with a misaligned offset or an unknown region is refused with an error pulse and never reaches the bus.

Top module: `wbb_bridge`

## Requirements
- R1: After reset, wbm_cyc_o, wbm_stb_o, busy, done and err are all low.
- R2: During a cycle, wbm_adr_o[63:59] holds 1 << (region code), with codes 0..3 selecting RAM banks 0..3 (bits 59..62) and code 4 selecting I/O (bit 63). Bits [58:40] are zero, bits [39:3] equal req_addr[39:3], and bits [2:0] are zero.
- R3: A request with region code 5, 6 or 7 is refused: err pulses, and no bus cycle starts.
- R4: req_size codes 0/1/2/3 mean 1/2/4/8 bytes. With offset o = req_addr[2:0] and n bytes, wbm_sel_o has ones exactly on bits 7-o down to 8-o-n.
- R5: On a write, wbm_we_o is 1 and wbm_dat_o equals the low n bytes of req_wdata shifted left by 8*(8-o-n) bits, with all other lanes zero. On a read, wbm_we_o is 0 and wbm_dat_o is zero.
- R6: On a read, rdata equals (wbm_dat_i >> 8*(8-o-n)) masked to n bytes, taken on the edge where ACK is sampled high and valid while done is high. After a write, rdata is zero.
- R7: A request whose offset is not a multiple of its size is refused. err is high for exactly one cycle after the request edge, and cyc, busy and done stay low.
- R8: wbm_cyc_o and wbm_stb_o rise together one cycle after acceptance. They stay high, with ADR, WE, SEL and DAT held stable, until ACK is sampled. Both drop on that edge, and done pulses for that single cycle.
- R9: busy is high from the cycle after acceptance until the cycle in which done is high, where it reads low. Requests presented while busy are ignored and change nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical byte address |
| req_region | input | 3 | Target region code (0-3 RAM bank, 4 I/O) |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Right-justified write value |
| busy | output | 1 | Bridge owns a bus cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rdata | output | 64 | Zero-extended read value |
| wbm_cyc_o | output | 1 | Wishbone cycle |
| wbm_stb_o | output | 1 | Wishbone strobe |
| wbm_we_o | output | 1 | Wishbone write enable |
| wbm_adr_o | output | 64 | Wishbone address |
| wbm_dat_o | output | 64 | Wishbone write data |
| wbm_sel_o | output | 8 | Wishbone byte selects |
| wbm_dat_i | input | 64 | Wishbone read data |
| wbm_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Every output is registered. Cycle, strobe, address, select, data and busy are therefore due one edge after the request edge, and the bench samples them on the following falling edge. The error pulse also appears one edge after the request and is checked on that falling edge and again one cycle later to prove it has cleared. done, rdata and the dropped cycle are due one edge after the edge that samples ACK. During the wait states the bench presents a conflicting request and re-checks the bus outputs on each falling edge, so that only ACK can end the cycle.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} size_e;
  typedef enum logic {ST_IDLE, ST_BUS} state_e;
endpackage

// File: rtl/wbb_addr_build.sv
module wbb_addr_build #(
  parameter int AW   = 64,
  parameter int PA_W = 40,
  parameter int NREG = 5,
  parameter int RC_W = 3,
  parameter int OW   = 3
) (
  input  logic [RC_W-1:0]    region,
  input  logic [PA_W-1:OW]   pa_hi,
  output logic [AW-1:0]      adr,
  output logic               region_bad
);
  localparam int GAP = AW - NREG - PA_W;

  logic [NREG-1:0] prefix;

  for (genvar r = 0; r < NREG; r++) begin : g_prefix
    assign prefix[r] = (region == RC_W'(r));
  end

  assign region_bad = (region >= RC_W'(NREG));
  assign adr = {prefix, {GAP{1'b0}}, pa_hi, {OW{1'b0}}};
endmodule

// File: rtl/wbb_lane_map.sv
module wbb_lane_map #(
  parameter int DW = 64,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL),
  localparam int SW = OW + 1
) (
  input  logic [1:0]    size,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wval,
  output logic [NL-1:0] sel,
  output logic [DW-1:0] wlane,
  output logic          misaligned,
  output logic [SW-1:0] lane_sh
);
  logic [SW:0]   nbytes;
  logic [SW:0]   offw;
  logic [SW:0]   sh_full;
  logic [NL-1:0] lane_en;
  logic [DW-1:0] keep;

  assign nbytes     = (SW+1)'(1) << size;
  assign offw       = (SW+1)'(off);
  assign sh_full    = (SW+1)'(NL) - offw - nbytes;
  assign lane_sh    = sh_full[SW-1:0];
  assign misaligned = |(offw & (nbytes - (SW+1)'(1)));

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lane_en[i]      = ((SW+1)'(i) < nbytes);
    assign keep[8*i +: 8]  = lane_en[i] ? wval[8*i +: 8] : 8'h00;
  end

  assign sel   = lane_en << lane_sh;
  assign wlane = keep << {lane_sh, 3'b000};
endmodule

// File: rtl/wbb_rd_align.sv
module wbb_rd_align #(
  parameter int DW = 64,
  localparam int NL = DW / 8,
  localparam int SW = $clog2(NL) + 1
) (
  input  logic [DW-1:0] bus,
  input  logic [SW-1:0] lane_sh,
  input  logic [1:0]    size,
  output logic [DW-1:0] val
);
  logic [SW:0]   nbytes;
  logic [DW-1:0] shifted;

  assign nbytes  = (SW+1)'(1) << size;
  assign shifted = bus >> {lane_sh, 3'b000};

  for (genvar i = 0; i < NL; i++) begin : g_mask
    assign val[8*i +: 8] = ((SW+1)'(i) < nbytes) ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/wbb_bridge.sv
module wbb_bridge #(
  parameter int AW   = 64,
  parameter int DW   = 64,
  parameter int PA_W = 40,
  parameter int NREG = 5,
  parameter int RC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [RC_W-1:0]   req_region,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  output logic              wbm_cyc_o,
  output logic              wbm_stb_o,
  output logic              wbm_we_o,
  output logic [AW-1:0]     wbm_adr_o,
  output logic [DW-1:0]     wbm_dat_o,
  output logic [DW/8-1:0]   wbm_sel_o,
  input  logic [DW-1:0]     wbm_dat_i,
  input  logic              wbm_ack_i
);
  import wbb_pkg::*;

  localparam int NL = DW / 8;
  localparam int OW = $clog2(NL);
  localparam int SW = OW + 1;

  state_e        state_q;
  logic [AW-1:0] adr_n;
  logic          region_bad;
  logic [NL-1:0] sel_n;
  logic [DW-1:0] dat_n;
  logic          misaligned;
  logic [SW-1:0] lane_sh_n;
  logic [SW-1:0] rd_sh_q;
  logic [1:0]    rd_size_q;
  logic [DW-1:0] rd_val;

  wbb_addr_build #(.AW(AW), .PA_W(PA_W), .NREG(NREG), .RC_W(RC_W), .OW(OW)) u_addr (
    .region     (req_region),
    .pa_hi      (req_addr[PA_W-1:OW]),
    .adr        (adr_n),
    .region_bad (region_bad)
  );

  wbb_lane_map #(.DW(DW)) u_lane (
    .size       (req_size),
    .off        (req_addr[OW-1:0]),
    .wval       (req_wdata),
    .sel        (sel_n),
    .wlane      (dat_n),
    .misaligned (misaligned),
    .lane_sh    (lane_sh_n)
  );

  wbb_rd_align #(.DW(DW)) u_rd (
    .bus     (wbm_dat_i),
    .lane_sh (rd_sh_q),
    .size    (rd_size_q),
    .val     (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wbm_we_o  <= 1'b0;
      wbm_adr_o <= '0;
      wbm_dat_o <= '0;
      wbm_sel_o <= '0;
      rd_sh_q   <= '0;
      rd_size_q <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (misaligned || region_bad) begin
              err <= 1'b1;
            end else begin
              state_q   <= ST_BUS;
              wbm_we_o  <= req_write;
              wbm_adr_o <= adr_n;
              wbm_sel_o <= sel_n;
              wbm_dat_o <= req_write ? dat_n : '0;
              rd_sh_q   <= lane_sh_n;
              rd_size_q <= req_size;
            end
          end
        end
        ST_BUS: begin
          if (wbm_ack_i) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            rdata   <= wbm_we_o ? '0 : rd_val;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wbm_cyc_o = (state_q == ST_BUS);
  assign wbm_stb_o = (state_q == ST_BUS);
  assign busy      = (state_q == ST_BUS);

  // R2: address format on the bus
  a_r2_adr_format: assert property (@(posedge clk) disable iff (rst)
    wbm_cyc_o |-> (wbm_adr_o[AW-NREG-1:PA_W] == '0) && (wbm_adr_o[OW-1:0] == '0)
                  && ($countones(wbm_adr_o[AW-1:AW-NREG]) == 1));

  // R4: a live cycle always selects at least one byte
  a_r4_sel_live: assert property (@(posedge clk) disable iff (rst)
    wbm_cyc_o |-> (wbm_sel_o != '0));

  // R7: a rejection never overlaps bus activity or completion
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!wbm_cyc_o && !done));

  // R8: bus signals held until ACK
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (wbm_cyc_o && !wbm_ack_i) |=> (wbm_cyc_o && wbm_stb_o && $stable(wbm_adr_o)
                                   && $stable(wbm_sel_o) && $stable(wbm_dat_o)
                                   && $stable(wbm_we_o)));

  // R8: ACK ends the cycle and raises done
  a_r8_ack_end: assert property (@(posedge clk) disable iff (rst)
    (wbm_cyc_o && wbm_ack_i) |=> (!wbm_cyc_o && !wbm_stb_o && done));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy is low while done is shown
  a_r9_busy_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_wbb_bridge.sv
module sim_wbb_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic [2:0]  req_region = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, done, err;
  logic [63:0] rdata;
  logic        wbm_cyc_o, wbm_stb_o, wbm_we_o;
  logic [63:0] wbm_adr_o, wbm_dat_o;
  logic [7:0]  wbm_sel_o;
  logic [63:0] wbm_dat_i = '0;
  logic        wbm_ack_i = 1'b0;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  wbb_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_region(req_region), .req_size(req_size),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .wbm_cyc_o(wbm_cyc_o), .wbm_stb_o(wbm_stb_o), .wbm_we_o(wbm_we_o),
    .wbm_adr_o(wbm_adr_o), .wbm_dat_o(wbm_dat_o), .wbm_sel_o(wbm_sel_o),
    .wbm_dat_i(wbm_dat_i), .wbm_ack_i(wbm_ack_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [39:0] addr, input logic [2:0] reg_c,
                        input logic [1:0] sz, input logic [63:0] wd,
                        input logic [63:0] bus_rd, input int wait_n);
    int          nb   = 1 << sz;
    int          off  = int'(addr[2:0]);
    bit          bad  = ((off % nb) != 0) || (reg_c > 3'd4);
    int          sh   = 8 - off - nb;
    logic [63:0] bmask = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - 8 * nb);
    logic [63:0] e_adr = (64'h1 << (59 + int'(reg_c))) | {24'h0, addr[39:3], 3'b000};
    logic [7:0]  e_sel = 8'((16'(1) << nb) - 16'(1)) << sh;
    logic [63:0] e_dat = wr ? ((wd & bmask) << (8 * sh)) : 64'h0;
    logic [63:0] e_rd  = wr ? 64'h0 : ((bus_rd >> (8 * sh)) & bmask);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_region = reg_c;
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(err == 1'b1, "R7/R3 err pulse", 64'(err), 64'h1);
      chk(!wbm_cyc_o && !busy && !done, "R7/R3 no cycle", 64'(wbm_cyc_o), 64'h0);
      @(negedge clk);
      chk(err == 1'b0 && !wbm_cyc_o, "R7 err one cycle", 64'(err), 64'h0);
      return;
    end
    chk(wbm_cyc_o && wbm_stb_o, "R8 cyc stb rise", 64'({wbm_cyc_o, wbm_stb_o}), 64'h3);
    chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'h1);
    chk(err == 1'b0, "R7 no err on good request", 64'(err), 64'h0);
    chk(wbm_adr_o == e_adr, "R2 address", wbm_adr_o, e_adr);
    chk(wbm_sel_o == e_sel, "R4 byte select", 64'(wbm_sel_o), 64'(e_sel));
    chk(wbm_we_o == wr, "R5 write enable", 64'(wbm_we_o), 64'(wr));
    chk(wbm_dat_o == e_dat, "R5 write lanes", wbm_dat_o, e_dat);
    for (int w = 0; w < wait_n; w++) begin
      req_valid = 1'b1; req_addr = ~addr; req_region = 3'd4 - reg_c[1:0];
      req_write = ~wr; req_wdata = ~wd;
      @(negedge clk);
      chk(wbm_cyc_o && busy && !done, "R8 held during wait", 64'(wbm_cyc_o), 64'h1);
      chk(wbm_adr_o == e_adr && wbm_sel_o == e_sel && wbm_dat_o == e_dat
          && wbm_we_o == wr, "R9 busy request ignored", wbm_adr_o, e_adr);
    end
    req_valid = 1'b0;
    wbm_ack_i = 1'b1; wbm_dat_i = bus_rd;
    @(negedge clk);
    wbm_ack_i = 1'b0; wbm_dat_i = ~bus_rd;
    chk(!wbm_cyc_o && !wbm_stb_o, "R8 drop after ack", 64'(wbm_cyc_o), 64'h0);
    chk(done == 1'b1 && busy == 1'b0, "R9 done with busy low", 64'({done, busy}), 64'h2);
    chk(rdata == e_rd, "R6 read data", rdata, e_rd);
    @(negedge clk);
    chk(done == 1'b0 && !wbm_cyc_o, "R8 done one cycle", 64'(done), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!wbm_cyc_o && !wbm_stb_o && !busy && !done && !err, "R1 reset state",
        64'({wbm_cyc_o, wbm_stb_o, busy, done, err}), 64'h0);
    for (int rg = 0; rg < 8; rg++)
      for (int sz = 0; sz < 4; sz++)
        for (int of = 0; of < 8; of++)
          for (int wr = 0; wr < 2; wr++) begin
            int          k  = ((rg * 4 + sz) * 8 + of) * 2 + wr;
            logic [39:0] a  = 40'h9F_1234_5670 + 40'(k * 8) + 40'(of);
            logic [63:0] wd = 64'hA5C3_1E7F_0B92_D846 + 64'(k) * 64'h9E37_79B9_7F4A_7C15;
            logic [63:0] bd = 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h0101_0101_0101_0101);
            do_req(wr[0], a, 3'(rg), 2'(sz), wd, bd, k % 4);
          end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule